// File: doc/BRIEF.md
# Control-Transfer Sequencer

This unit owns the 16-bit instruction pointer of a small microcoded 8-bit processor. It carries out every control-transfer instruction: absolute jumps, calls that leave the return address in a link register, calls and returns that use a byte-wide stack in memory, and signed relative branches. Each sequence makes at most one byte-wide memory access per cycle. When an accepted opcode is presented with `start_i`, the unit runs one step per clock and raises `done_o` in the last step, so the fetch logic can load the next opcode.

The pointer registers P, Q (link) and S (stack) are held outside the unit. The unit reads them on `p_i`, `q_i` and `s_i`, and writes Q and S back through write-enable/value pairs, which take effect on the clock edge that ends the step. Memory is treated as combinational: `mem_rdata_i` must be valid in the cycle that `mem_rd_o` is high. A write happens on the edge that ends a cycle in which `mem_wr_o` is high. When an opcode is accepted, the instruction pointer already points at the byte after the opcode.

Top module: `xfer_seq`

## Requirements
- R1: While reset is low, and after it is released, the instruction pointer is 0, and `mem_rd_o`, `mem_wr_o`, `done_o`, `q_wr_o` and `s_wr_o` are all low until an opcode is accepted.
- R2: Opcode 0x60 takes 3 steps. It reads the byte at I, which is the high byte, then the byte at I+1, which is the low byte, and then sets I to {high, low}. Q and S are left unchanged.
- R3: Opcode 0x63 behaves like R2. In its final step it also writes Q with the address that follows the two immediate bytes.
- R4: Opcodes 0x64 and 0x66 take 1 step. They set I to P or to Q respectively, and leave Q unchanged.
- R5: Opcodes 0x65 and 0x67 take 1 step. They set I to P or to Q respectively, and write Q with the incoming I. For 0x67 the two values are exchanged.
- R6: Opcode 0xE2 takes 5 steps: two immediate reads, a push of the high byte of (I-1) at address S, a push of the low byte at S+1, and then the jump to {high, low}. Here I is the address after the immediates. S ends 2 higher and I does not change during the pushes.
- R7: Opcodes 0xE4 and 0xE5 take 3 steps. They push (I-1) as in R6, high byte first, and then set I to P or to Q respectively.
- R8: Opcode 0xE1 takes 3 steps. It reads the low byte at S-1 and then the high byte at S-2, decrementing S before each read. It then sets I to {high, low}+1.
- R9: Opcode 0x31 takes 2 steps. It reads a signed byte d at I and then sets I to I+1+d, modulo 2^16.
- R10: Opcode 0x30 branches as in R9 only when `zero_i` is low, and opcode 0x32 only when it is high. When the branch is not taken, the sequence ends in its read step (1 step) with I one past the offset byte.
- R11: S wraps modulo 2^16 on both push and pop.
- R12: No cycle has both `mem_rd_o` and `mem_wr_o` high. `done_o` is high for exactly one cycle per sequence, and the unit is idle in the cycle after it.
- R13: An opcode outside those listed above is ignored: no memory request, no done and no change to I. `start_i` and `opcode_i` are ignored while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opcode valid; sampled only when idle |
| opcode_i | input | 8 | Decoded opcode |
| zero_i | input | 1 | Zero flag, sampled in the branch read step |
| p_i | input | 16 | Current P register |
| q_i | input | 16 | Current Q (link) register |
| s_i | input | 16 | Current stack pointer |
| mem_rdata_i | input | 8 | Read data, valid in the request cycle |
| pc_o | output | 16 | Instruction pointer |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| q_wr_o | output | 1 | Write enable for Q |
| q_o | output | 16 | New Q value |
| s_wr_o | output | 1 | Write enable for S |
| s_o | output | 16 | New S value |
| done_o | output | 1 | Last step of a sequence |

## Verification
Step 1 of a sequence is active in the cycle after the edge that accepts `start_i`. The strobes, the address and `done_o` are combinational within each step. I, Q and S change on the edge that ends the step in which `done_o` is high. The bench drives its inputs and samples at falling edges. It counts steps from the accepting edge up to the falling edge where `done_o` is seen, compares that count with the step count each requirement states, and then waits one more edge before it compares I, Q, S and the pushed bytes.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int OPW = 8;

  localparam logic [OPW-1:0] OPC_JMP_IMM = 8'h60;
  localparam logic [OPW-1:0] OPC_JSR_IMM = 8'h63;
  localparam logic [OPW-1:0] OPC_JMP_P   = 8'h64;
  localparam logic [OPW-1:0] OPC_JSR_P   = 8'h65;
  localparam logic [OPW-1:0] OPC_JMP_Q   = 8'h66;
  localparam logic [OPW-1:0] OPC_JSR_Q   = 8'h67;
  localparam logic [OPW-1:0] OPC_RET_STK = 8'hE1;
  localparam logic [OPW-1:0] OPC_JSS_IMM = 8'hE2;
  localparam logic [OPW-1:0] OPC_JSS_P   = 8'hE4;
  localparam logic [OPW-1:0] OPC_JSS_Q   = 8'hE5;
  localparam logic [OPW-1:0] OPC_BR_NZ   = 8'h30;
  localparam logic [OPW-1:0] OPC_BR_AL   = 8'h31;
  localparam logic [OPW-1:0] OPC_BR_Z    = 8'h32;

  typedef enum logic [3:0] {
    K_NONE, K_JMP_IMM, K_JSR_IMM, K_JMP_REG, K_JSR_REG,
    K_JSS_IMM, K_JSS_REG, K_RET, K_BR
  } kind_e;

  typedef enum logic [1:0] { C_ALWAYS, C_NZ, C_Z } cond_e;

  typedef struct packed {
    kind_e kind;
    logic  src_q;
    cond_e cond;
  } dec_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_IMM_HI, ST_IMM_LO, ST_PUSH_HI, ST_PUSH_LO,
    ST_POP_LO, ST_POP_HI, ST_REL_RD, ST_REL_ADD, ST_XFER
  } step_e;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
(
  input  logic [OPW-1:0] opcode_i,
  output dec_t           dec_o
);
  always_comb begin
    dec_o = '{kind: K_NONE, src_q: 1'b0, cond: C_ALWAYS};
    case (opcode_i)
      OPC_JMP_IMM: dec_o.kind = K_JMP_IMM;
      OPC_JSR_IMM: dec_o.kind = K_JSR_IMM;
      OPC_JMP_P:   dec_o.kind = K_JMP_REG;
      OPC_JMP_Q:   begin dec_o.kind = K_JMP_REG; dec_o.src_q = 1'b1; end
      OPC_JSR_P:   dec_o.kind = K_JSR_REG;
      OPC_JSR_Q:   begin dec_o.kind = K_JSR_REG; dec_o.src_q = 1'b1; end
      OPC_JSS_IMM: dec_o.kind = K_JSS_IMM;
      OPC_JSS_P:   dec_o.kind = K_JSS_REG;
      OPC_JSS_Q:   begin dec_o.kind = K_JSS_REG; dec_o.src_q = 1'b1; end
      OPC_RET_STK: dec_o.kind = K_RET;
      OPC_BR_AL:   dec_o.kind = K_BR;
      OPC_BR_NZ:   begin dec_o.kind = K_BR; dec_o.cond = C_NZ; end
      OPC_BR_Z:    begin dec_o.kind = K_BR; dec_o.cond = C_Z; end
      default:     dec_o.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  dec_t  dec_i,
  input  logic  zero_i,
  output step_e step_o,
  output kind_e kind_o,
  output logic  src_q_o,
  output logic  mem_rd_o,
  output logic  mem_wr_o,
  output logic  done_o
);
  step_e state_q, state_d;
  dec_t  info_q;
  logic  taken;

  always_comb begin
    case (info_q.cond)
      C_NZ:    taken = !zero_i;
      C_Z:     taken = zero_i;
      default: taken = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        case (dec_i.kind)
          K_JMP_IMM, K_JSR_IMM, K_JSS_IMM: state_d = ST_IMM_HI;
          K_JMP_REG, K_JSR_REG:            state_d = ST_XFER;
          K_JSS_REG:                       state_d = ST_PUSH_HI;
          K_RET:                           state_d = ST_POP_LO;
          K_BR:                            state_d = ST_REL_RD;
          default:                         state_d = ST_IDLE;
        endcase
      end
      ST_IMM_HI:  state_d = ST_IMM_LO;
      ST_IMM_LO:  state_d = (info_q.kind == K_JSS_IMM) ? ST_PUSH_HI : ST_XFER;
      ST_PUSH_HI: state_d = ST_PUSH_LO;
      ST_PUSH_LO: state_d = ST_XFER;
      ST_POP_LO:  state_d = ST_POP_HI;
      ST_POP_HI:  state_d = ST_XFER;
      ST_REL_RD:  state_d = taken ? ST_REL_ADD : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      info_q  <= '{kind: K_NONE, src_q: 1'b0, cond: C_ALWAYS};
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) info_q <= dec_i;
    end
  end

  assign step_o   = state_q;
  assign kind_o   = info_q.kind;
  assign src_q_o  = info_q.src_q;
  assign mem_rd_o = (state_q == ST_IMM_HI) || (state_q == ST_IMM_LO) ||
                    (state_q == ST_POP_LO) || (state_q == ST_POP_HI) ||
                    (state_q == ST_REL_RD);
  assign mem_wr_o = (state_q == ST_PUSH_HI) || (state_q == ST_PUSH_LO);
  assign done_o   = (state_q == ST_XFER) || (state_q == ST_REL_ADD) ||
                    (state_q == ST_REL_RD && !taken);

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && state_q == ST_IDLE));
  // R6
  push_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH_HI) |=> (state_q == ST_PUSH_LO));
  // R8
  pop_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POP_LO) |=> (state_q == ST_POP_HI));
  // R13
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(info_q));
  // R12
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o}));
endmodule

// File: rtl/xfer_dpath.sv
module xfer_dpath
  import xfer_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          AW       = 2 * DW,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  step_e         step_i,
  input  kind_e         kind_i,
  input  logic          src_q_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [AW-1:0] p_i,
  input  logic [AW-1:0] q_i,
  input  logic [AW-1:0] s_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          q_wr_o,
  output logic [AW-1:0] q_o,
  output logic          s_wr_o,
  output logic [AW-1:0] s_o
);
  logic [AW-1:0] pc_q, pc_d, ret_m1, s_inc, s_dec, pair, rel_sum;
  logic [DW-1:0] hi_q, lo_q;

  assign ret_m1  = pc_q - AW'(1);
  assign s_inc   = s_i + AW'(1);
  assign s_dec   = s_i - AW'(1);
  assign pair    = {hi_q, lo_q};
  assign rel_sum = pc_q + {{(AW-DW){lo_q[DW-1]}}, lo_q};

  always_comb begin
    pc_d        = pc_q;
    mem_addr_o  = pc_q;
    mem_wdata_o = '0;
    q_wr_o      = 1'b0;
    q_o         = pc_q;
    s_wr_o      = 1'b0;
    s_o         = s_i;
    case (step_i)
      ST_IMM_HI, ST_IMM_LO, ST_REL_RD: pc_d = pc_q + AW'(1);
      ST_PUSH_HI: begin
        mem_addr_o  = s_i;
        mem_wdata_o = ret_m1[AW-1:DW];
        s_wr_o      = 1'b1;
        s_o         = s_inc;
      end
      ST_PUSH_LO: begin
        mem_addr_o  = s_i;
        mem_wdata_o = ret_m1[DW-1:0];
        s_wr_o      = 1'b1;
        s_o         = s_inc;
      end
      ST_POP_LO, ST_POP_HI: begin
        mem_addr_o = s_dec;
        s_wr_o     = 1'b1;
        s_o        = s_dec;
      end
      ST_REL_ADD: pc_d = rel_sum;
      ST_XFER: begin
        case (kind_i)
          K_JMP_IMM, K_JSR_IMM, K_JSS_IMM: pc_d = pair;
          K_JMP_REG, K_JSR_REG, K_JSS_REG: pc_d = src_q_i ? q_i : p_i;
          K_RET:                           pc_d = pair + AW'(1);
          default:                         pc_d = pc_q;
        endcase
        q_wr_o = (kind_i == K_JSR_IMM) || (kind_i == K_JSR_REG);
      end
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= RESET_PC;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (step_i == ST_IMM_HI || step_i == ST_POP_HI) hi_q <= mem_rdata_i;
      if (step_i == ST_IMM_LO || step_i == ST_POP_LO || step_i == ST_REL_RD)
        lo_q <= mem_rdata_i;
    end
  end

  assign pc_o = pc_q;

  // R2
  imm_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_IMM_HI || step_i == ST_IMM_LO || step_i == ST_REL_RD)
      |=> (pc_q == $past(pc_q) + AW'(1)));
  // R6
  stack_pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_PUSH_HI || step_i == ST_PUSH_LO ||
     step_i == ST_POP_LO  || step_i == ST_POP_HI) |=> $stable(pc_q));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_IDLE) |-> (!q_wr_o && !s_wr_o));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            AW       = 2 * DW,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [OPW-1:0] opcode_i,
  input  logic           zero_i,
  input  logic [AW-1:0]  p_i,
  input  logic [AW-1:0]  q_i,
  input  logic [AW-1:0]  s_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [AW-1:0]  pc_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           q_wr_o,
  output logic [AW-1:0]  q_o,
  output logic           s_wr_o,
  output logic [AW-1:0]  s_o,
  output logic           done_o
);
  dec_t  dec;
  step_e step;
  kind_e kind;
  logic  src_q;

  xfer_decode u_dec (.opcode_i(opcode_i), .dec_o(dec));

  xfer_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dec_i(dec),
    .zero_i(zero_i), .step_o(step), .kind_o(kind), .src_q_o(src_q),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .done_o(done_o)
  );

  xfer_dpath #(.DW(DW), .AW(AW), .RESET_PC(RESET_PC)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .kind_i(kind),
    .src_q_i(src_q), .mem_rdata_i(mem_rdata_i), .p_i(p_i), .q_i(q_i),
    .s_i(s_i), .pc_o(pc_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .q_wr_o(q_wr_o), .q_o(q_o),
    .s_wr_o(s_wr_o), .s_o(s_o)
  );
endmodule

// File: tb/sim_xfer_seq.sv
module sim_xfer_seq;
  typedef struct packed {
    logic [7:0]  op;
    logic        zf;
    logic [15:0] pc0, p, q, s;
    logic [7:0]  b0, b1, slo, shi;
    logic [15:0] e_pc, e_q, e_s;
    logic [3:0]  steps;
    logic        push;
    logic [7:0]  m0, m1;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{8'h60,1'b0,16'h1210,16'h0000,16'hAAAA,16'h0480,8'h34,8'h56,8'h00,8'h00,16'h3456,16'hAAAA,16'h0480,4'd3,1'b0,8'h00,8'h00,4'd2},  // R2
    '{8'h63,1'b0,16'h2220,16'h0000,16'hAAAA,16'h0480,8'h12,8'h9A,8'h00,8'h00,16'h129A,16'h2222,16'h0480,4'd3,1'b0,8'h00,8'h00,4'd3},  // R3
    '{8'h64,1'b0,16'h0030,16'h4321,16'hAAAA,16'h0480,8'h00,8'h00,8'h00,8'h00,16'h4321,16'hAAAA,16'h0480,4'd1,1'b0,8'h00,8'h00,4'd4},  // R4
    '{8'h66,1'b0,16'h0030,16'h0000,16'h5AA5,16'h0480,8'h00,8'h00,8'h00,8'h00,16'h5AA5,16'h5AA5,16'h0480,4'd1,1'b0,8'h00,8'h00,4'd4},  // R4
    '{8'h65,1'b0,16'h0040,16'h1111,16'hAAAA,16'h0480,8'h00,8'h00,8'h00,8'h00,16'h1111,16'h0040,16'h0480,4'd1,1'b0,8'h00,8'h00,4'd5},  // R5
    '{8'h67,1'b0,16'h0050,16'h0000,16'h7777,16'h0480,8'h00,8'h00,8'h00,8'h00,16'h7777,16'h0050,16'h0480,4'd1,1'b0,8'h00,8'h00,4'd5},  // R5
    '{8'hE2,1'b0,16'h3360,16'h0000,16'hAAAA,16'h0480,8'hBE,8'hEF,8'h00,8'h00,16'hBEEF,16'hAAAA,16'h0482,4'd5,1'b1,8'h33,8'h61,4'd6},  // R6
    '{8'hE4,1'b0,16'h0470,16'h2468,16'hAAAA,16'h0490,8'h00,8'h00,8'h00,8'h00,16'h2468,16'hAAAA,16'h0492,4'd3,1'b1,8'h04,8'h6F,4'd7},  // R7
    '{8'hE5,1'b0,16'h0100,16'h0000,16'h1357,16'hFFFF,8'h00,8'h00,8'h00,8'h00,16'h1357,16'h1357,16'h0001,4'd3,1'b1,8'h00,8'hFF,4'd11}, // R11 push wrap
    '{8'hE1,1'b0,16'h00C0,16'h0000,16'hAAAA,16'h04A2,8'h00,8'h00,8'h0F,8'h20,16'h2010,16'hAAAA,16'h04A0,4'd3,1'b0,8'h00,8'h00,4'd8},  // R8
    '{8'hE1,1'b0,16'h00C0,16'h0000,16'hAAAA,16'h0001,8'h00,8'h00,8'hFF,8'h12,16'h1300,16'hAAAA,16'hFFFF,4'd3,1'b0,8'h00,8'h00,4'd11}, // R11 pop wrap
    '{8'h31,1'b0,16'h10D0,16'h0000,16'hAAAA,16'h0480,8'h05,8'h00,8'h00,8'h00,16'h10D6,16'hAAAA,16'h0480,4'd2,1'b0,8'h00,8'h00,4'd9},  // R9
    '{8'h31,1'b0,16'h10E0,16'h0000,16'hAAAA,16'h0480,8'hF0,8'h00,8'h00,8'h00,16'h10D1,16'hAAAA,16'h0480,4'd2,1'b0,8'h00,8'h00,4'd9},  // R9 negative
    '{8'h30,1'b0,16'h2010,16'h0000,16'hAAAA,16'h0480,8'h7F,8'h00,8'h00,8'h00,16'h2090,16'hAAAA,16'h0480,4'd2,1'b0,8'h00,8'h00,4'd10}, // R10
    '{8'h30,1'b1,16'h2020,16'h0000,16'hAAAA,16'h0480,8'h40,8'h00,8'h00,8'h00,16'h2021,16'hAAAA,16'h0480,4'd1,1'b0,8'h00,8'h00,4'd10}, // R10
    '{8'h32,1'b1,16'h2030,16'h0000,16'hAAAA,16'h0480,8'h80,8'h00,8'h00,8'h00,16'h1FB1,16'hAAAA,16'h0480,4'd2,1'b0,8'h00,8'h00,4'd10}, // R10
    '{8'h32,1'b0,16'h2040,16'h0000,16'hAAAA,16'h0480,8'h00,8'h00,8'h00,8'h00,16'h2041,16'hAAAA,16'h0480,4'd1,1'b0,8'h00,8'h00,4'd10}, // R10
    '{8'h31,1'b0,16'hFFF0,16'h0000,16'hAAAA,16'h0480,8'h20,8'h00,8'h00,8'h00,16'h0011,16'hAAAA,16'h0480,4'd2,1'b0,8'h00,8'h00,4'd9}   // R9 wrap
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, zero, mem_rd, mem_wr, q_wr, s_wr, done;
  logic [7:0]  opcode, mem_rdata, mem_wdata;
  logic [15:0] p_r, q_r, s_r, pc, mem_addr, q_nx, s_nx;
  logic [7:0]  mem [0:255];
  logic        poke_en, ld_en;
  logic [7:0]  poke_a, poke_d;
  logic [15:0] ld_q, ld_s;
  int          n_chk = 0, n_bad = 0;

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (poke_en) mem[poke_a] <= poke_d;
    else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (ld_en) begin
      q_r <= ld_q;
      s_r <= ld_s;
    end else begin
      if (q_wr) q_r <= q_nx;
      if (s_wr) s_r <= s_nx;
    end
  end

  xfer_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .zero_i(zero), .p_i(p_r), .q_i(q_r), .s_i(s_r), .mem_rdata_i(mem_rdata),
    .pc_o(pc), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .q_wr_o(q_wr), .q_o(q_nx), .s_wr_o(s_wr),
    .s_o(s_nx), .done_o(done)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    poke_a = a; poke_d = d; poke_en = 1'b1;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic set_qs(input logic [15:0] q, input logic [15:0] s);
    ld_q = q; ld_s = s; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // starts and ends at a falling edge; results are settled on return
  task automatic run(input logic [7:0] op, input logic zf, input bit hold,
                     output int steps, output bit dbl);
    opcode = op; zero = zf; start = 1'b1;
    @(posedge clk);
    steps = 0; dbl = 1'b0;
    forever begin
      @(negedge clk);
      if (hold) opcode = 8'h64;
      else start = 1'b0;
      steps++;
      if (mem_rd && mem_wr) dbl = 1'b1;
      if (done || steps > 8) begin
        start = 1'b0;
        break;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int  steps;
    bit  dbl;
    rst_n = 1'b0; start = 1'b0; opcode = '0; zero = 1'b0; p_r = '0;
    poke_en = 1'b0; poke_a = '0; poke_d = '0; ld_en = 1'b1;
    ld_q = 16'hAAAA; ld_s = 16'h0480;
    @(negedge clk); @(negedge clk);
    ld_en = 1'b0;
    // R1
    chk("R1 pc in reset", pc, 16'h0000);
    chk("R1 strobes in reset", {13'd0, mem_rd, mem_wr, done}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after reset", pc, 16'h0000);
    chk("R1 idle outputs", {12'd0, mem_rd, mem_wr, q_wr, s_wr}, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VEC[k];
      p_r = v.pc0;
      run(8'h64, 1'b0, 1'b0, steps, dbl);
      poke(v.pc0[7:0], v.b0);
      poke(8'(v.pc0 + 16'd1), v.b1);
      poke(8'(v.s - 16'd1), v.slo);
      poke(8'(v.s - 16'd2), v.shi);
      set_qs(v.q, v.s);
      p_r = v.p;
      run(v.op, v.zf, 1'b0, steps, dbl);
      chk($sformatf("R%0d steps op %h", v.req, v.op), 16'(steps), {12'd0, v.steps});
      chk($sformatf("R%0d pc op %h", v.req, v.op), pc, v.e_pc);
      chk($sformatf("R%0d q op %h", v.req, v.op), q_r, v.e_q);
      chk($sformatf("R%0d s op %h", v.req, v.op), s_r, v.e_s);
      // R12
      chk("R12 single request", {15'd0, dbl}, 16'h0000);
      chk("R12 done one cycle", {15'd0, done}, 16'h0000);
      if (v.push) begin
        chk($sformatf("R%0d pushed high", v.req), {8'd0, mem[v.s[7:0]]}, {8'd0, v.m0});
        chk($sformatf("R%0d pushed low", v.req), {8'd0, mem[8'(v.s + 16'd1)]}, {8'd0, v.m1});
      end
    end

    // R13 unknown opcode is ignored
    p_r = 16'h0077;
    run(8'h64, 1'b0, 1'b0, steps, dbl);
    poke(8'h77, 8'h0A);
    poke(8'h78, 8'hBC);
    opcode = 8'h61; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dbl = 1'b0;
    for (int c = 0; c < 4; c++) begin
      if (mem_rd || mem_wr || done) dbl = 1'b1;
      @(negedge clk);
    end
    chk("R13 no activity on unknown opcode", {15'd0, dbl}, 16'h0000);
    chk("R13 pc unchanged", pc, 16'h0077);

    // R13 start and opcode changes while busy are ignored
    p_r = 16'h5555;
    run(8'h60, 1'b0, 1'b1, steps, dbl);
    chk("R13 busy steps", 16'(steps), 16'd3);
    chk("R13 busy pc", pc, 16'h0ABC);
    @(negedge clk);
    chk("R13 idle after held start", {15'd0, mem_rd}, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule